// File: doc/BRIEF.md
# Burst Address Counter with Masked Wrap

This block generates the address for one synchronous memory port so that sequential accesses need no new address every cycle. On each rising clock edge three active-low controls choose one operation: clear, load an external start address, step to the next address, or hold. Every load also copies the start address into a base register.

A programmable mask chooses which address bits count. A mask bit of 1 marks a counting bit, and a mask bit of 0 marks a bit that keeps its loaded value. The counting bits therefore set the burst boundary. When all counting bits are one, an active-low interrupt flags the boundary, and the next step returns the counter to the base address. With the mask all ones, which is the reset value, the counter covers the whole address space and steps from all ones to zero.

Top module: `burst_addr_ctr`

## Requirements
- R1: The controls `ads_ni`, `cnt_en_ni` and `cnt_rst_ni` are active low and are sampled on the rising edge of `clk_i`. When `cnt_rst_ni` is low, the counter and the base register both become 0, whatever the other controls are.
- R2: When `cnt_rst_ni` is high and `ads_ni` is low, `addr_i` is captured into the counter and into the base register. This happens whatever the level of `cnt_en_ni`.
- R3: When only `cnt_en_ni` is low, the counting bits (mask bit 1) advance by one, with the carry skipping masked bits. The masked bits (mask bit 0) keep their values. A step can happen on every cycle.
- R4: When all three controls are high, `addr_o` holds its value.
- R5: With the mask all ones, a step from the all-ones address gives 0 with no idle cycle, whatever the base register holds.
- R6: With any other mask, a step taken while all counting bits are one loads the base register into the counter.
- R7: `cnt_int_no` is low exactly when every counting bit of `addr_o` is one. It follows `addr_o` in the same cycle.
- R8: The mask register is written from `mask_i` on a rising edge when `mask_we_i` is high. A step taken in the same cycle uses the previous mask.
- R9: While `rst_ni` is low, the counter and the base register are 0 and the mask is all ones, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_ni | input | 1 | Address strobe (load), active low |
| cnt_en_ni | input | 1 | Count enable (step), active low |
| cnt_rst_ni | input | 1 | Synchronous counter clear, active low |
| addr_i | input | AW | External start address |
| mask_we_i | input | 1 | Mask register write enable |
| mask_i | input | AW | Mask write data, 1 = counting bit |
| addr_o | output | AW | Current address |
| cnt_int_no | output | 1 | Boundary interrupt, active low |

## Verification
Two cases put two functions in the same cycle.

- **Load against step.** A strobe and a step request arrive together, and a clear arrives together with a strobe. The value on `addr_o` on the next cycle must show that the higher-priority operation alone took effect.
- **Mask write against step.** A mask write arrives in the same cycle as a step. The resulting address must match the step computed under the old mask. The mask's effect must then show on the following step and on the interrupt.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import burst_ctr_pkg::*;
(
  input  logic    ads_ni,
  input  logic    cnt_en_ni,
  input  logic    cnt_rst_ni,
  output ctr_op_e op_o
);
  // clear > load > step > hold
  always_comb begin
    if (!cnt_rst_ni)     op_o = OP_CLR;
    else if (!ads_ni)    op_o = OP_LOAD;
    else if (!cnt_en_ni) op_o = OP_INC;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/ctr_mask_reg.sv
module ctr_mask_reg #(
  parameter int AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/ctr_step.sv
module ctr_step #(
  parameter int AW = 17
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  output logic [AW-1:0] next_o,
  output logic          at_bound_o
);
  localparam logic [AW-1:0] FULL = '1;

  logic [AW-1:0] filled;
  logic [AW-1:0] bumped;
  logic          full_span;

  // force masked bits to 1 so the carry ripples past them
  assign filled     = addr_i | ~mask_i;
  assign bumped     = filled + 1'b1;
  assign at_bound_o = &filled;
  assign full_span  = (mask_i == FULL);

  always_comb begin
    if (at_bound_o && !full_span) next_o = base_i;
    else next_o = (addr_i & ~mask_i) | (bumped & mask_i);
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_ctr_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ads_ni,
  input  logic          cnt_en_ni,
  input  logic          cnt_rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          mask_we_i,
  input  logic [AW-1:0] mask_i,
  output logic [AW-1:0] addr_o,
  output logic          cnt_int_no
);
  ctr_op_e       op;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] mask_q;
  logic [AW-1:0] step_addr;
  logic          at_bound;

  ctr_op_decode i_decode (
    .ads_ni     (ads_ni),
    .cnt_en_ni  (cnt_en_ni),
    .cnt_rst_ni (cnt_rst_ni),
    .op_o       (op)
  );

  ctr_mask_reg #(.AW(AW)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we_i),
    .d_i    (mask_i),
    .q_o    (mask_q)
  );

  ctr_step #(.AW(AW)) i_step (
    .addr_i     (cnt_q),
    .base_i     (base_q),
    .mask_i     (mask_q),
    .next_o     (step_addr),
    .at_bound_o (at_bound)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      case (op)
        OP_CLR: begin
          cnt_q  <= '0;
          base_q <= '0;
        end
        OP_LOAD: begin
          cnt_q  <= addr_i;
          base_q <= addr_i;
        end
        OP_INC:  cnt_q <= step_addr;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign addr_o     = cnt_q;
  assign cnt_int_no = ~at_bound;
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int AW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ads_ni,
  input logic          cnt_en_ni,
  input logic          cnt_rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          mask_we_i,
  input logic [AW-1:0] mask_i,
  input logic [AW-1:0] addr_o,
  input logic          cnt_int_no
);
  logic [AW-1:0] shadow_mask;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        shadow_mask <= '1;
    else if (mask_we_i) shadow_mask <= mask_i;
  end

  assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_rst_ni |=> addr_o == '0);

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && !ads_ni) |=> addr_o == $past(addr_i));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && ads_ni && cnt_en_ni) |=> $stable(addr_o));

  // away from the boundary a step never disturbs masked bits
  assert_masked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && ads_ni && !cnt_en_ni && cnt_int_no)
      |=> ((addr_o ^ $past(addr_o)) & ~$past(shadow_mask)) == '0);

  assert_full_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && ads_ni && !cnt_en_ni && shadow_mask == '1 && addr_o == '1)
      |=> addr_o == '0);

  assert_int_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_int_no |-> (addr_o & shadow_mask) == shadow_mask);
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ads_ni     (ads_ni),
  .cnt_en_ni  (cnt_en_ni),
  .cnt_rst_ni (cnt_rst_ni),
  .addr_i     (addr_i),
  .mask_we_i  (mask_we_i),
  .mask_i     (mask_i),
  .addr_o     (addr_o),
  .cnt_int_no (cnt_int_no)
);

// File: tb/test_burst_addr_ctr.sv
`timescale 1ns/1ps
module test_burst_addr_ctr;
  localparam int AW = 17;

  typedef struct packed {
    logic          ads_n;
    logic          en_n;
    logic          clr_n;
    logic [AW-1:0] a;
    logic [AW-1:0] exp_a;
    logic          exp_int_n;
  } vec_t;

  // full mask (reset value) throughout
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 1'b1, 17'h1FFFE, 17'h1FFFE, 1'b1},  // R2 load
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h1FFFF, 1'b0},  // R3 step, R7 int
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h00000, 1'b1},  // R5 wrap to zero
    '{1'b1, 1'b1, 1'b1, 17'h0ABCD, 17'h00000, 1'b1},  // R4 hold
    '{1'b0, 1'b0, 1'b1, 17'h00100, 17'h00100, 1'b1},  // R2 load beats step
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h00101, 1'b1},  // R3 step
    '{1'b0, 1'b0, 1'b0, 17'h00055, 17'h00000, 1'b1},  // R1 clear beats load
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h00001, 1'b1}   // R3 step
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ads_n = 1'b1, en_n = 1'b1, clr_n = 1'b1, mwe = 1'b0;
  logic [AW-1:0] a = '0, mdat = '0;
  logic [AW-1:0] addr;
  logic          int_n;
  int            n_run = 0, n_fail = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  burst_addr_ctr #(.AW(AW)) i_burst_addr_ctr (
    .clk_i(clk), .rst_ni(rst_n), .ads_ni(ads_n), .cnt_en_ni(en_n),
    .cnt_rst_ni(clr_n), .addr_i(a), .mask_we_i(mwe), .mask_i(mdat),
    .addr_o(addr), .cnt_int_no(int_n)
  );

  task automatic chk(string req, logic [AW-1:0] ea, logic ei);
    n_run++;
    if (addr !== ea || int_n !== ei) begin
      n_fail++;
      $display("FAIL %s: addr=%h int_n=%b expected addr=%h int_n=%b", req, addr, int_n, ea, ei);
    end
  endtask

  // drive after falling edge, apply on rising edge, sample 1 ns later
  task automatic cyc(logic s, logic e, logic c, logic [AW-1:0] ad, logic w, logic [AW-1:0] m);
    @(negedge clk);
    ads_n = s; en_n = e; clr_n = c; a = ad; mwe = w; mdat = m;
    @(posedge clk);
    #1;
    ads_n = 1'b1; en_n = 1'b1; clr_n = 1'b1; mwe = 1'b0;
  endtask

  task automatic step();
    cyc(1'b1, 1'b0, 1'b1, '0, 1'b0, '0);
  endtask

  task automatic load(logic [AW-1:0] ad);
    cyc(1'b0, 1'b1, 1'b1, ad, 1'b0, '0);
  endtask

  task automatic setmask(logic [AW-1:0] m);
    cyc(1'b1, 1'b1, 1'b1, '0, 1'b1, m);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R9 reset state", '0, 1'b1);
    @(negedge clk) rst_n = 1'b1;

    foreach (VECS[i]) begin
      cyc(VECS[i].ads_n, VECS[i].en_n, VECS[i].clr_n, VECS[i].a, 1'b0, '0);
      chk($sformatf("R1-table vec %0d", i), VECS[i].exp_a, VECS[i].exp_int_n);
    end

    // R6 masked wrap reloads base
    setmask(17'h0000F);
    load(17'h1234D);  chk("R2 masked load", 17'h1234D, 1'b1);
    step();           chk("R3 masked step", 17'h1234E, 1'b1);
    step();           chk("R7 boundary int", 17'h1234F, 1'b0);
    step();           chk("R6 reload base", 17'h1234D, 1'b1);

    // R3 non-contiguous mask: carry skips bits 1..3
    setmask(17'h00011);
    load(17'h00000);
    step();           chk("R3 skip step 1", 17'h00001, 1'b1);
    step();           chk("R3 skip step 2", 17'h00010, 1'b1);
    step();           chk("R7 sparse bound", 17'h00011, 1'b0);
    step();           chk("R6 sparse reload", 17'h00000, 1'b1);

    // R1 clear also zeroes base
    setmask(17'h00003);
    load(17'h00008);
    clr_and_run();

    // R8 mask write during step uses old mask
    load(17'h00003);  chk("R7 bound mask3", 17'h00003, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, '0, 1'b1, 17'h0000F);
    chk("R8 old mask used", 17'h00003, 1'b1);
    step();           chk("R8 new mask active", 17'h00004, 1'b1);

    // R9 async reset restores full mask
    @(negedge clk) rst_n = 1'b0;
    #2 chk("R9 async clear", '0, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    load(17'h1FFFF);  chk("R9 full mask int", 17'h1FFFF, 1'b0);
    step();           chk("R5 full wrap", 17'h00000, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic clr_and_run();
    cyc(1'b1, 1'b1, 1'b0, 17'h00000, 1'b0, '0);
    chk("R1 clear", 17'h00000, 1'b1);
    step(); step(); step();
    chk("R7 mask3 bound", 17'h00003, 1'b0);
    step();
    chk("R1 base cleared", 17'h00000, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule